// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a small up counter that runs through a power-of-two sequence of states, four bits wide by default. All changes happen on the rising clock edge, except that the clear can be built to act at once. Four controls pick what happens: an active-low clear, an active-low parallel load, and two active-high count enables. The priority is fixed: clear wins over load, load wins over counting, and counting wins over holding.

The two count enables do different jobs. The count advances only when both are high. Only the trickle enable feeds the terminal-count flag, which is high when the counter holds its all-ones value. To make a wider counter, stages are chained: each stage's terminal count drives the trickle enable of the next stage, and all stages share one parallel enable. A low parallel enable then freezes the whole chain. The ripple through the chain is combinational, so a chained stage reacts in the same cycle.

The parameter `ASYNC_CLEAR` sets how the clear works. With 1, a low clear resets the register at once, with no clock edge needed. With 0, the clear is one more synchronous mode that takes effect at the next rising edge.

Top module: `cascade_counter`

## Requirements
- R1: The count has WIDTH bits (default 4). Counting from the all-ones value (15 by default) gives 0 on the next rising edge.
- R2: The modes have a fixed priority: clear first, then parallel load, then count, then hold. A low clear wins over a low load, and a low load wins over both count enables being high.
- R3: With ASYNC_CLEAR=1, a low clearN drives countOut to 0 without waiting for a clock edge. The count stays at 0 across rising edges while clearN is low, whatever the other inputs are.
- R4: With ASYNC_CLEAR=0, a low clearN leaves countOut unchanged until the next rising edge, which sets it to 0.
- R5: With clear inactive, a low loadN copies parIn into the count on the next rising edge, whatever the count enables are.
- R6: With clearN and loadN high, and enPar and enTrickle both high, the count goes up by one on each rising edge.
- R7: With clearN and loadN high, a low level on enPar or on enTrickle keeps the count unchanged across the edge.
- R8: termCount is 1 exactly when countOut is all ones and enTrickle is 1. It does not depend on enPar, and it follows its inputs in the same cycle.
- R9: Two stages chained as in the description count as one 2×WIDTH-bit counter and wrap from all ones to 0. A low shared enPar freezes both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| clearN | input | 1 | Active-low clear; asynchronous or synchronous, set by ASYNC_CLEAR |
| loadN | input | 1 | Active-low parallel load |
| enPar | input | 1 | Parallel count enable, active high |
| enTrickle | input | 1 | Trickle count enable, active high; also gates termCount |
| parIn | input | WIDTH | Value loaded by the parallel load |
| countOut | output | WIDTH | Current count |
| termCount | output | 1 | High when the count is all ones and enTrickle is high |

## Verification
The synchronous results (load, count, hold, synchronous clear) show up on countOut one rising edge after the inputs that cause them. The bench sets inputs on the falling edge and reads the outputs on the next falling edge, so every check sees the register exactly one update after its stimulus. termCount and the asynchronous clear need no edge. They are checked a few nanoseconds after the inputs change, with no clock edge in between. For the synchronous variant, the bench also reads the count before the edge, to show that the clear has not acted early.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  // Strobes from the mode decode to the datapath; at most one is high.
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doInc;
  } cntStrobes_t;
endpackage

// File: rtl/cascade_counter_ctrl.sv
module cascade_counter_ctrl
  import cascade_counter_pkg::*;
#(
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic        clearN,
  input  logic        loadN,
  input  logic        enPar,
  input  logic        enTrickle,
  output logic        regArstN,
  output cntStrobes_t strobes
);
  logic syncClear;

  // The parameter picks where the clear goes: into the register's reset
  // pin, or into the edge-driven mode decode.
  generate
    if (ASYNC_CLEAR) begin : g_asyncClear
      assign regArstN  = clearN;
      assign syncClear = 1'b0;
    end else begin : g_syncClear
      assign regArstN  = 1'b1;
      assign syncClear = ~clearN;
    end
  endgenerate

  // Priority order: clear, then load, then count; hold when no strobe is high.
  always_comb begin
    strobes.doClear = syncClear;
    strobes.doLoad  = ~syncClear & ~loadN;
    strobes.doInc   = ~syncClear & loadN & enPar & enTrickle;
  end
endmodule

// File: rtl/cascade_counter_dp.sv
module cascade_counter_dp
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             regArstN,
  input  cntStrobes_t      strobes,
  input  logic [WIDTH-1:0] parIn,
  input  logic             enTrickle,
  output logic [WIDTH-1:0] countOut,
  output logic             termCount
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countD;

  always_comb begin
    countD = countQ;
    if (strobes.doClear)     countD = ZERO;
    else if (strobes.doLoad) countD = parIn;
    else if (strobes.doInc)  countD = countQ + STEP;
  end

  // regArstN is tied high in the synchronous-clear build.
  always_ff @(posedge clk or negedge regArstN) begin
    if (!regArstN) countQ <= ZERO;
    else           countQ <= countD;
  end

  assign countOut  = countQ;
  // Combinational, so a chained stage sees it in the same cycle.
  assign termCount = (&countQ) & enTrickle;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             enPar,
  input  logic             enTrickle,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] countOut,
  output logic             termCount
);
  cntStrobes_t strobes;
  logic        regArstN;

  cascade_counter_ctrl #(.ASYNC_CLEAR(ASYNC_CLEAR)) u_ctrl (
    .clearN    (clearN),
    .loadN     (loadN),
    .enPar     (enPar),
    .enTrickle (enTrickle),
    .regArstN  (regArstN),
    .strobes   (strobes)
  );

  cascade_counter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .regArstN  (regArstN),
    .strobes   (strobes),
    .parIn     (parIn),
    .enTrickle (enTrickle),
    .countOut  (countOut),
    .termCount (termCount)
  );
endmodule

// File: rtl/cascade_counter_checker.sv
module cascade_counter_checker #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadN,
  input logic             enPar,
  input logic             enTrickle,
  input logic [WIDTH-1:0] parIn,
  input logic [WIDTH-1:0] countOut,
  input logic             termCount
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);
  logic pastValid = 1'b0;

  always_ff @(posedge clk) pastValid <= 1'b1;

  // R2 / R3 / R4: a clear seen at an edge leaves the count at zero.
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!pastValid)
    !clearN |=> countOut == '0);

  // R5: load captures the data word, whatever the enables are.
  assert_load_capture_R5: assert property (@(posedge clk) disable iff (!pastValid || !clearN)
    (clearN && !loadN) |=> countOut == $past(parIn));

  // R6 and R1: increment by one, wrapping modulo 2**WIDTH.
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!pastValid || !clearN)
    (clearN && loadN && enPar && enTrickle) |=> countOut == WIDTH'($past(countOut) + STEP));

  // R7: either enable low holds the count.
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!pastValid || !clearN)
    (clearN && loadN && !(enPar && enTrickle)) |=> $stable(countOut));

  // R8: terminal-count decode.
  assert_tc_decode_R8: assert property (@(posedge clk) disable iff (!pastValid)
    termCount == ((countOut == {WIDTH{1'b1}}) && enTrickle));

  generate
    if (ASYNC_CLEAR) begin : g_asyncChk
      // R3: with the asynchronous clear, a low clear already shows as zero at the edge.
      assert_async_zero_R3: assert property (@(posedge clk) disable iff (!pastValid)
        !clearN |-> countOut == '0);
    end
  endgenerate
endmodule

bind cascade_counter cascade_counter_checker #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_chk (
  .clk       (clk),
  .clearN    (clearN),
  .loadN     (loadN),
  .enPar     (enPar),
  .enTrickle (enTrickle),
  .parIn     (parIn),
  .countOut  (countOut),
  .termCount (termCount)
);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       clearN = 1'b0;
  logic       syncClearN = 1'b0;
  logic       loadN = 1'b1;
  logic       enPar = 1'b0;
  logic       enTrickle = 1'b0;
  logic [3:0] parIn = 4'd0;
  logic [3:0] hiPar = 4'd0;

  logic [3:0] loCount, hiCount, sCount;
  logic       loTc, hiTc, sTc;

  int nApplied = 0;
  int nBad = 0;

  logic [3:0] expLo = 4'd0;
  logic [3:0] expHi = 4'd0;
  logic [3:0] expS  = 4'd0;

  // Low stage of the chain: asynchronous clear.
  cascade_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) dut (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enPar(enPar),
    .enTrickle(enTrickle), .parIn(parIn), .countOut(loCount), .termCount(loTc));

  // High stage: trickle enable comes from the low stage's terminal count.
  cascade_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) dutHi (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enPar(enPar),
    .enTrickle(loTc), .parIn(hiPar), .countOut(hiCount), .termCount(hiTc));

  // Synchronous-clear build, driven by the same data controls.
  cascade_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) dutSync (
    .clk(clk), .clearN(syncClearN), .loadN(loadN), .enPar(enPar),
    .enTrickle(enTrickle), .parIn(parIn), .countOut(sCount), .termCount(sTc));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nApplied++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] nxt(input logic [3:0] c, input logic clr, input logic ld,
                                     input logic ep, input logic et, input logic [3:0] p);
    if (!clr) return 4'd0;
    if (!ld) return p;
    if (ep && et) return c + 4'd1;
    return c;
  endfunction

  // Inputs are set before the call, at a falling edge; apply one rising edge, check on the next falling edge.
  task automatic tick(input string tag);
    logic [3:0] nLo, nHi, nS;
    logic tcLo;
    tcLo = (expLo == 4'hF) && enTrickle;
    nLo = nxt(expLo, clearN, loadN, enPar, enTrickle, parIn);
    nHi = nxt(expHi, clearN, loadN, enPar, tcLo, hiPar);
    nS  = nxt(expS, syncClearN, loadN, enPar, enTrickle, parIn);
    @(posedge clk);
    @(negedge clk);
    expLo = nLo; expHi = nHi; expS = nS;
    chk(tag, {4'd0, loCount}, {4'd0, expLo});
    chk(tag, {4'd0, hiCount}, {4'd0, expHi});
    chk(tag, {4'd0, sCount}, {4'd0, expS});
    chk({tag, " R8"}, {7'd0, loTc}, {7'd0, (expLo == 4'hF) && enTrickle});
  endtask

  task automatic test_reset();
    // R3: the asynchronous clear acts before any edge.
    #3;
    chk("R3 async clear lo", {4'd0, loCount}, 8'd0);
    chk("R3 async clear hi", {4'd0, hiCount}, 8'd0);
    @(negedge clk);
    tick("R4 sync clear at edge");
    clearN = 1'b1; syncClearN = 1'b1;
  endtask

  task automatic test_load_priority();
    loadN = 1'b0; enPar = 1'b1; enTrickle = 1'b1; parIn = 4'd9; hiPar = 4'd2;
    tick("R5 load over count R2");
    chk("R5 load value", {4'd0, loCount}, 8'd9);
    loadN = 1'b1;
    tick("R6 count");
    tick("R6 count");
    chk("R6 two steps", {4'd0, sCount}, 8'd11);
  endtask

  task automatic test_wrap_tc();
    loadN = 1'b0; parIn = 4'd14;
    tick("R5 load 14");
    loadN = 1'b1;
    tick("R6 to 15");
    chk("R8 tc at 15", {7'd0, sTc}, 8'd1);
    enPar = 1'b0;
    #2 chk("R8 tc ignores enPar", {7'd0, loTc}, 8'd1);
    enTrickle = 1'b0;
    #2 chk("R8 tc needs trickle", {7'd0, loTc}, 8'd0);
    @(negedge clk);
    tick("R7 hold both low");
    enPar = 1'b1;
    tick("R7 hold trickle low");
    chk("R7 held 15", {4'd0, sCount}, 8'd15);
    enTrickle = 1'b1;
    tick("R1 wrap");
    chk("R1 wrap to 0", {4'd0, sCount}, 8'd0);
  endtask

  task automatic test_clear_priority();
    loadN = 1'b0; parIn = 4'd5;
    tick("R5 load 5");
    syncClearN = 1'b0; loadN = 1'b0; parIn = 4'd7;
    #2 chk("R4 no change before edge", {4'd0, sCount}, 8'd5);
    @(negedge clk);
    tick("R2 clear over load");
    chk("R2 sync zero", {4'd0, sCount}, 8'd0);
    syncClearN = 1'b1; loadN = 1'b1;
    tick("R6 after clear");
    // R3: async clear mid-cycle with load active, then across an edge.
    #3 clearN = 1'b0; loadN = 1'b0;
    #2 chk("R3 immediate zero", {4'd0, loCount}, 8'd0);
    @(negedge clk);
    tick("R3 held across edge");
    clearN = 1'b1; loadN = 1'b1;
  endtask

  task automatic test_chain();
    clearN = 1'b0; syncClearN = 1'b0;
    tick("R9 reset chain");
    clearN = 1'b1; syncClearN = 1'b1; enPar = 1'b1; enTrickle = 1'b1;
    for (int i = 0; i < 255; i++) tick("R9 chain count");
    chk("R9 chain at FF", {hiCount, loCount}, 8'hFF);
    tick("R9 chain wrap");
    chk("R9 chain at 00", {hiCount, loCount}, 8'h00);
    loadN = 1'b0; parIn = 4'hF; hiPar = 4'h3;
    tick("R9 load 3F");
    loadN = 1'b1; enPar = 1'b0;
    tick("R9 freeze");
    chk("R9 frozen 3F", {hiCount, loCount}, 8'h3F);
    enPar = 1'b1;
    tick("R9 carry");
    chk("R9 carry to 40", {hiCount, loCount}, 8'h40);
  endtask

  initial begin
    #(20 * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nBad);
    $finish;
  end

  initial begin
    test_reset();
    test_load_priority();
    test_wrap_tc();
    test_clear_priority();
    test_chain();
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nBad);
    $finish;
  end
endmodule